// File: doc/BRIEF.md
# DMA Flash Window Access Checker

This block screens read requests that a DMA engine aims at on-chip flash. Software sets up a window for DMA use. The window has a start address and a length counted in 2 KB regions. An enable bit switches DMA access to flash on and off. A per-region protection mask then says which 2 KB regions DMA may touch.

A request is granted only if all of the following hold:
- the chip is in run mode;
- the enable bit is set;
- the address falls inside the window;
- the mask bit for the addressed region is set.

Any request that fails one of these tests produces a bus fault. A refused request is never dropped without a response.

Each request is judged against the settings present in the same cycle. The result appears one clock later as a single-cycle pulse on either the grant output or the fault output. The DMA engine and the flash read path sit outside this block.

Top module: `fdw_access_screen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both grant and fault are low.
- R2: For every cycle with req_valid high, exactly one of grant or fault is high in the following cycle for one cycle only. After a cycle with req_valid low, both are low.
- R3: The region index of an address is its bits [ADDR_W-1:11]. A request is inside the window only if its region index is at least the start region and less than the start region plus win_size. A request whose region is below the start region, or at or beyond the end, faults.
- R4: Bits [10:0] of win_start are ignored, so the window always begins on a 2 KB boundary.
- R5: A win_size of zero makes every request fault.
- R6: With win_en low, every request faults.
- R7: With run_mode low (low-power mode), every request faults.
- R8: region_mask bit k set allows region k. Bit k clear makes a request to region k fault, even inside the window.
- R9: A window that reaches past the top of flash does not wrap around. Regions below the start region still fault.
- R10: The settings are sampled in the same cycle as the request. A change in the next cycle affects only the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A DMA flash read request is present this cycle |
| req_addr | input | ADDR_W | Byte address of the request within flash |
| win_en | input | 1 | DMA access to flash is enabled |
| win_start | input | ADDR_W | Window start address; the low 11 bits are ignored |
| win_size | input | SIZE_W | Window length in 2 KB regions |
| region_mask | input | N_REGIONS | One bit per 2 KB region; 1 means DMA may read it |
| run_mode | input | 1 | 1 in run mode, 0 in any low-power mode |
| grant | output | 1 | Pulse: the previous cycle's request is allowed |
| fault | output | 1 | Pulse: the previous cycle's request is refused with a bus fault |

## Verification
The first request pattern uses a fixed four-region window. It probes the first and last regions inside the window and the regions just below and just past it. This tells an inclusive end apart from an exclusive one, and an off-by-one start apart from a correct one.

Further patterns each remove a single gate while leaving the others passing:
- a start address with low bits set;
- a zero size;
- enable low;
- run mode low;
- a cleared mask bit inside the window.

A fault in each of these cases can only come from the gate under test.

A window that hangs past the top of flash is probed with one request just under the top and one at address zero, which separates clipping from wraparound. Back-to-back requests with the settings changing between them show that the settings are sampled together with the request.

// File: rtl/fdw_pkg.sv
package fdw_pkg;

    // Log2 of the region granule (2 KB)
    localparam int REGION_SHIFT = 11;

    typedef enum logic [2:0] {
        VERDICT_OK       = 3'd0,
        VERDICT_NOT_RUN  = 3'd1,
        VERDICT_DISABLED = 3'd2,
        VERDICT_OUTSIDE  = 3'd3,
        VERDICT_MASKED   = 3'd4,
        VERDICT_IDLE     = 3'd5
    } verdict_e;

    typedef struct packed {
        logic grant;
        logic fault;
    } resp_t;

endpackage

// File: rtl/fdw_range_cmp.sv
module fdw_range_cmp #(
    parameter int REG_W  = 7,
    parameter int SIZE_W = REG_W + 1
) (
    input  logic [REG_W-1:0]  req_region,
    input  logic [REG_W-1:0]  start_region,
    input  logic [SIZE_W-1:0] size_regions,
    output logic              in_window
);

    logic             at_or_above;
    logic [REG_W-1:0] offset;

    always_comb begin
        at_or_above = (req_region >= start_region);
        offset      = req_region - start_region;
        // The offset is below 2**REG_W, so it cannot overflow SIZE_W bits.
        in_window   = at_or_above && (SIZE_W'(offset) < size_regions);
    end

endmodule

// File: rtl/fdw_region_lookup.sv
module fdw_region_lookup #(
    parameter int REG_W     = 7,
    parameter int N_REGIONS = 1 << REG_W
) (
    input  logic [REG_W-1:0]     req_region,
    input  logic [N_REGIONS-1:0] region_mask,
    output logic                 region_open
);

    logic [N_REGIONS-1:0] hit;

    // Decode the region index, then AND-OR with the mask.
    for (genvar k = 0; k < N_REGIONS; k++) begin : g_dec
        assign hit[k] = (req_region == REG_W'(k)) && region_mask[k];
    end

    assign region_open = |hit;

endmodule

// File: rtl/fdw_access_screen.sv
module fdw_access_screen
    import fdw_pkg::*;
#(
    parameter int ADDR_W = 18,
    localparam int REG_W     = ADDR_W - REGION_SHIFT,
    localparam int SIZE_W    = REG_W + 1,
    localparam int N_REGIONS = 1 << REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 win_en,
    input  logic [ADDR_W-1:0]    win_start,
    input  logic [SIZE_W-1:0]    win_size,
    input  logic [N_REGIONS-1:0] region_mask,
    input  logic                 run_mode,
    output logic                 grant,
    output logic                 fault
);

    logic [REG_W-1:0] req_region;
    logic [REG_W-1:0] start_region;
    logic             in_window;
    logic             region_open;
    logic             unused_low_bits;
    verdict_e         verdict;
    resp_t            resp_d;
    resp_t            resp_q;

    assign req_region      = req_addr[ADDR_W-1:REGION_SHIFT];
    assign start_region    = win_start[ADDR_W-1:REGION_SHIFT];
    assign unused_low_bits = ^{req_addr[REGION_SHIFT-1:0], win_start[REGION_SHIFT-1:0]};

    fdw_range_cmp #(
        .REG_W  (REG_W),
        .SIZE_W (SIZE_W)
    ) range_i (
        .req_region   (req_region),
        .start_region (start_region),
        .size_regions (win_size),
        .in_window    (in_window)
    );

    fdw_region_lookup #(
        .REG_W     (REG_W),
        .N_REGIONS (N_REGIONS)
    ) lookup_i (
        .req_region  (req_region),
        .region_mask (region_mask),
        .region_open (region_open)
    );

    always_comb begin
        if (!req_valid)        verdict = VERDICT_IDLE;
        else if (!run_mode)    verdict = VERDICT_NOT_RUN;
        else if (!win_en)      verdict = VERDICT_DISABLED;
        else if (!in_window)   verdict = VERDICT_OUTSIDE;
        else if (!region_open) verdict = VERDICT_MASKED;
        else                   verdict = VERDICT_OK;

        resp_d       = '0;
        resp_d.grant = (verdict == VERDICT_OK);
        resp_d.fault = (verdict != VERDICT_OK) && (verdict != VERDICT_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign grant = resp_q.grant;
    assign fault = resp_q.fault;

endmodule

// File: rtl/fdw_access_screen_chk.sv
module fdw_access_screen_chk #(
    parameter int ADDR_W    = 18,
    parameter int SIZE_W    = 8,
    parameter int N_REGIONS = 128
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 win_en,
    input logic [ADDR_W-1:0]    win_start,
    input logic [SIZE_W-1:0]    win_size,
    input logic [N_REGIONS-1:0] region_mask,
    input logic                 run_mode,
    input logic                 grant,
    input logic                 fault
);

    // R2
    excl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && fault));

    // R2
    one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (grant ^ fault));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!grant && !fault));

    // R7
    lowpower_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !run_mode) |=> fault);

    // R6
    disabled_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !win_en) |=> fault);

    // R5
    zero_size_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (win_size == '0)) |=> fault);

    // R3
    below_start_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr[ADDR_W-1:11] < win_start[ADDR_W-1:11])) |=> fault);

    // R8
    masked_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !region_mask[req_addr[ADDR_W-1:11]]) |=> fault);

endmodule

bind fdw_access_screen fdw_access_screen_chk #(
    .ADDR_W    (ADDR_W),
    .SIZE_W    (SIZE_W),
    .N_REGIONS (N_REGIONS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .win_en      (win_en),
    .win_start   (win_start),
    .win_size    (win_size),
    .region_mask (region_mask),
    .run_mode    (run_mode),
    .grant       (grant),
    .fault       (fault)
);

// File: tb/fdw_access_screen_tb.sv
module fdw_access_screen_tb_top;

    localparam int ADDR_W = 18;
    localparam int SIZE_W = 8;
    localparam int NREG   = 128;

    typedef struct packed {
        logic [17:0] addr;
        logic [17:0] start;
        logic [7:0]  size;
        logic        en;
        logic        run;
        logic        exp_grant;
        logic [3:0]  rq;
    } vec_t;

    // Regions 5 and 70 are closed by the mask.
    localparam logic [NREG-1:0] MASK = ~((128'd1 << 5) | (128'd1 << 70));

    localparam int NVEC = 13;
    localparam vec_t VECS [NVEC] = '{
        '{18'h02000, 18'h02000, 8'd4,   1'b1, 1'b1, 1'b1, 4'd3},  // R3 first region
        '{18'h03FFC, 18'h02000, 8'd4,   1'b1, 1'b1, 1'b1, 4'd3},  // R3 last region
        '{18'h04000, 18'h02000, 8'd4,   1'b1, 1'b1, 1'b0, 4'd3},  // R3 end excluded
        '{18'h01FFC, 18'h02000, 8'd4,   1'b1, 1'b1, 1'b0, 4'd3},  // R3 below start
        '{18'h02800, 18'h02000, 8'd4,   1'b1, 1'b1, 1'b0, 4'd8},  // R8 region 5 closed
        '{18'h02000, 18'h027FF, 8'd1,   1'b1, 1'b1, 1'b1, 4'd4},  // R4 low bits ignored
        '{18'h02000, 18'h02000, 8'd0,   1'b1, 1'b1, 1'b0, 4'd5},  // R5 zero size
        '{18'h02000, 18'h02000, 8'd4,   1'b0, 1'b1, 1'b0, 4'd6},  // R6 disabled
        '{18'h02000, 18'h02000, 8'd4,   1'b1, 1'b0, 1'b0, 4'd7},  // R7 low power
        '{18'h3F800, 18'h3F000, 8'd10,  1'b1, 1'b1, 1'b1, 4'd9},  // R9 top region
        '{18'h00000, 18'h3F000, 8'd10,  1'b1, 1'b1, 1'b0, 4'd9},  // R9 no wrap
        '{18'h23000, 18'h00000, 8'd255, 1'b1, 1'b1, 1'b0, 4'd8},  // R8 region 70 closed
        '{18'h22800, 18'h00000, 8'd255, 1'b1, 1'b1, 1'b1, 4'd8}   // R8 region 69 open
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              win_en;
    logic [ADDR_W-1:0] win_start;
    logic [SIZE_W-1:0] win_size;
    logic [NREG-1:0]   region_mask;
    logic              run_mode;
    logic              grant;
    logic              fault;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    fdw_access_screen #(.ADDR_W(ADDR_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .win_en      (win_en),
        .win_start   (win_start),
        .win_size    (win_size),
        .region_mask (region_mask),
        .run_mode    (run_mode),
        .grant       (grant),
        .fault       (fault)
    );

    task automatic check(input string tag, input logic g, input logic f);
        n_checks++;
        if (grant !== g || fault !== f) begin
            n_fails++;
            $display("FAIL %s actual grant=%b fault=%b expected grant=%b fault=%b",
                     tag, grant, fault, g, f);
        end
    endtask

    task automatic drive(input logic v, input logic [17:0] a, input logic [17:0] s,
                         input logic [7:0] sz, input logic e, input logic r);
        req_valid = v; req_addr = a; win_start = s;
        win_size = sz; win_en = e; run_mode = r;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        region_mask = MASK;
        drive(1'b1, 18'h02000, 18'h02000, 8'd4, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0);
        drive(1'b0, 18'h0, 18'h0, 8'd0, 1'b0, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0);

        // Table walk: drive at negedge, the result is registered at the next posedge.
        for (int i = 0; i < NVEC; i++) begin
            drive(1'b1, VECS[i].addr, VECS[i].start, VECS[i].size, VECS[i].en, VECS[i].run);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VECS[i].rq, i),
                  VECS[i].exp_grant, ~VECS[i].exp_grant);
        end

        // R10: settings change between back-to-back requests
        drive(1'b1, 18'h02000, 18'h02000, 8'd4, 1'b1, 1'b1);
        @(negedge clk);
        check("R10 first of pair", 1'b1, 1'b0);
        drive(1'b1, 18'h02000, 18'h02000, 8'd4, 1'b0, 1'b1);
        @(negedge clk);
        check("R10 second of pair", 1'b0, 1'b1);
        drive(1'b1, 18'h02000, 18'h02000, 8'd4, 1'b1, 1'b1);
        @(negedge clk);
        check("R10 third of pair", 1'b1, 1'b0);

        // R2: pulse lasts a single cycle, idle gives nothing
        drive(1'b0, 18'h02000, 18'h02000, 8'd4, 1'b1, 1'b1);
        @(negedge clk);
        check("R2 idle after grant", 1'b0, 1'b0);
        @(negedge clk);
        check("R2 still idle", 1'b0, 1'b0);

        // R8: opening region 5 makes it grant
        region_mask = '1;
        drive(1'b1, 18'h02800, 18'h02000, 8'd4, 1'b1, 1'b1);
        @(negedge clk);
        check("R8 region 5 reopened", 1'b1, 1'b0);
        drive(1'b0, 18'h0, 18'h0, 8'd0, 1'b0, 1'b1);
        @(negedge clk);
        check("R2 idle at end", 1'b0, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule